// File: doc/BRIEF.md
# I2C Serial Memory Target Engine

This block is the bus-side protocol engine of a byte-addressed serial memory with 16K locations. It watches the two-wire bus through oversampling in the system clock domain and finds start and stop conditions. It takes in bytes most significant bit first and drives a single pull-low enable that the pad turns into an open-drain SDA. After a matching select byte it runs the memory command sequences: a single-byte write, a page write, a random read made of a dummy write and a repeated start, a read from the current address, and a sequential read.

The array, the page buffer and the protect register are not part of this block. Each data byte it accepts goes out as a one-cycle write strobe with its address. A separate strobe marks a legal end of a write, so that the memory side can start its program cycle. While that cycle runs the memory side holds `busy_i`, and the engine then stays off the bus. The memory side also reports through `wr_protect_i` whether the location being written is protected. Read data comes back combinationally for the address the engine presents.

Top module: `i2c_mem_target`

## Requirements
- R1: Out of reset and after any stop, the engine does not pull SDA. It responds only after a start, which is SDA falling while SCL is high. A stop is SDA rising while SCL is high.
- R2: The first byte after a start is acknowledged only when its upper seven bits equal 1010001: 0xA2 for a write and 0xA3 for a read, where bit 0 = 1 means read. On any other value there is no acknowledge, and every following byte is ignored until the next start.
- R3: A write carries two address bytes after the select byte, and each is acknowledged. The low 14 bits of {first, second} form the array address, and bit 7 of the first byte selects the protect register. Each data byte then gives one `wr_req_o` strobe carrying the counter address and the byte.
- R4: Successive data bytes in one write advance only the low 5 address bits. They wrap inside the 32-byte page and the upper bits stay fixed.
- R5: `commit_o` pulses only for a stop that comes directly after the acknowledge slot of an acknowledged data byte. A stop after the address bytes alone gives no commit.
- R6: A dummy write of the address, followed by a repeated start with 0xA3, returns the byte at that address. Bits that are 0 are driven as a pull.
- R7: A read with no address phase starts at the internal counter. The counter advances after every output byte and wraps from 0x3FFF to 0x0000.
- R8: A master NoAck (SDA high in the 9th clock) after an output byte ends the transfer. Further clocks see no drive until a new start.
- R9: While `busy_i` is high, the select byte is not acknowledged and no write strobe is issued, so a master can poll for completion.
- R10: A data byte addressed to a location flagged by `wr_protect_i` gets NoAck and no write strobe, and it does not enable a commit.
- R11: While the protect register is selected, the address counter does not advance, so repeated read bytes all return the register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| sda_pull_o | output | 1 | High pulls SDA low (ACK or a read bit of 0) |
| busy_i | input | 1 | Memory program cycle in progress |
| rd_addr_o | output | 16 | Read address: bit 15 selects the protect register, low 14 bits are the array address |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, combinational |
| wr_req_o | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr_o | output | 16 | Address for `wr_req_o`, same format as `rd_addr_o` |
| wr_data_o | output | 8 | Data for `wr_req_o` |
| wr_protect_i | input | 1 | Location at `wr_addr_o` is write protected |
| commit_o | output | 1 | One-cycle strobe: start the program cycle |

## Verification
A wrong phase or bit count shows up at the next 9th clock as a missing or unexpected pull, so it is seen within one byte time. A wrong address counter gives no bus error but a wrong write strobe address or a wrong read byte at the very next data byte, which the bench compares byte by byte. Faulty commit gating shows only at a stop. For that reason the bench ends writes both at the legal slot and after the address bytes alone.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT
  } phase_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl_o  = scl_sh[SYNC_STAGES-1];
  assign sda_lvl_o  = sda_sh[SYNC_STAGES-1];
  assign scl_rise_o = scl_lvl_o & ~scl_q;
  assign scl_fall_o = ~scl_lvl_o & scl_q;
  assign start_o    = scl_lvl_o & scl_q & sda_q & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_q & ~sda_q & sda_lvl_o;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_val_i,
  input  logic              inc_page_i,
  input  logic              inc_lin_i,
  output logic [ADDR_W-1:0] cnt_o
);
  localparam logic [ADDR_W-1:0] A_ONE  = 1;
  localparam logic [PAGE_W-1:0] PG_ONE = 1;

  logic [ADDR_W-1:0] cnt_q, cnt_n;
  logic [PAGE_W-1:0] pg_inc;

  assign pg_inc = cnt_q[PAGE_W-1:0] + PG_ONE;

  always_comb begin
    cnt_n = cnt_q;
    if (ld_i)            cnt_n = ld_val_i;
    else if (inc_lin_i)  cnt_n = cnt_q + A_ONE;
    else if (inc_page_i) cnt_n = {cnt_q[ADDR_W-1:PAGE_W], pg_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inc_page_i && !ld_i && !inc_lin_i) |-> cnt_q[ADDR_W-1:PAGE_W] == $past(cnt_q[ADDR_W-1:PAGE_W])); // R4
  AST_LINEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inc_lin_i && !ld_i && (&cnt_q)) |-> cnt_q == '0); // R7
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter int         ADDR_W      = 14,
  parameter int         PAGE_W      = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ID      = 7'b1010001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic        busy_i,
  output logic [15:0] rd_addr_o,
  input  logic [7:0]  rd_data_i,
  output logic        wr_req_o,
  output logic [15:0] wr_addr_o,
  output logic [7:0]  wr_data_o,
  input  logic        wr_protect_i,
  output logic        commit_o
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int PAD_W = 15 - ADDR_W;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_c), .stop_o(stop_c)
  );

  phase_t          ph_q, ph_n;
  logic [3:0]      bit_q, bit_n;
  logic [7:0]      sh_q, sh_n;
  logic            pull_q, pull_n;
  logic [HI_W:0]   hi_q, hi_n;
  logic            sel_q, sel_n;
  logic            dseen_q, dseen_n;
  logic            mnack_q, mnack_n;
  logic            ctr_ld, ctr_inc_pg, ctr_inc_ln, wr_fire, commit;
  logic [ADDR_W-1:0] cnt;
  logic [2:0]      rd_idx;

  assign rd_idx = 3'(4'd7 - bit_q);

  i2c_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld_i(ctr_ld), .ld_val_i({hi_q[HI_W-1:0], sh_q}),
    .inc_page_i(ctr_inc_pg), .inc_lin_i(ctr_inc_ln), .cnt_o(cnt)
  );

  always_comb begin
    ph_n = ph_q;  bit_n = bit_q;  sh_n = sh_q;  pull_n = pull_q;
    hi_n = hi_q;  sel_n = sel_q;  dseen_n = dseen_q;  mnack_n = mnack_q;
    ctr_ld = 1'b0;  ctr_inc_pg = 1'b0;  ctr_inc_ln = 1'b0;
    wr_fire = 1'b0;  commit = 1'b0;
    if (busy_i) begin
      ph_n = PH_IDLE;  pull_n = 1'b0;  bit_n = '0;  dseen_n = 1'b0;
    end else if (start_c) begin
      ph_n = PH_DEV;  pull_n = 1'b0;  bit_n = '0;  dseen_n = 1'b0;
    end else if (stop_c) begin
      commit  = (ph_q == PH_WDAT) && dseen_q && (bit_q <= 4'd1);
      ph_n    = PH_IDLE;  pull_n = 1'b0;  bit_n = '0;  dseen_n = 1'b0;
    end else if (ph_q != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) begin
          if (ph_q != PH_RDAT) sh_n = {sh_q[6:0], sda_lvl};
          bit_n = bit_q + 4'd1;
        end else if (bit_q == 4'd8) begin
          bit_n   = 4'd9;
          mnack_n = sda_lvl;
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          case (ph_q)
            PH_DEV:  pull_n = (sh_q[7:1] == DEV_ID);
            PH_AHI:  begin hi_n = {sh_q[7], sh_q[HI_W-1:0]}; pull_n = 1'b1; end
            PH_ALO:  begin ctr_ld = 1'b1; sel_n = hi_q[HI_W]; pull_n = 1'b1; end
            PH_WDAT: begin
              wr_fire    = !wr_protect_i;
              pull_n     = !wr_protect_i;
              dseen_n    = dseen_q | !wr_protect_i;
              ctr_inc_pg = !sel_q;
            end
            PH_RDAT: begin pull_n = 1'b0; ctr_inc_ln = !sel_q; end
            default: pull_n = 1'b0;
          endcase
        end else if (bit_q == 4'd9) begin
          bit_n  = '0;
          pull_n = 1'b0;
          case (ph_q)
            PH_DEV: begin
              if (sh_q[7:1] != DEV_ID) ph_n = PH_IDLE;
              else if (sh_q[0]) begin
                ph_n = PH_RDAT;  sh_n = rd_data_i;  pull_n = ~rd_data_i[7];
              end else ph_n = PH_AHI;
            end
            PH_AHI: ph_n = PH_ALO;
            PH_ALO: ph_n = PH_WDAT;
            PH_RDAT: begin
              if (mnack_q) ph_n = PH_IDLE;
              else begin sh_n = rd_data_i; pull_n = ~rd_data_i[7]; end
            end
            default: ph_n = ph_q;
          endcase
        end else if (ph_q == PH_RDAT && bit_q != 4'd0) begin
          pull_n = ~sh_q[rd_idx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  bit_q <= '0;  sh_q <= '0;  pull_q <= 1'b0;
      hi_q <= '0;  sel_q <= 1'b0;  dseen_q <= 1'b0;  mnack_q <= 1'b0;
    end else begin
      ph_q <= ph_n;  bit_q <= bit_n;  sh_q <= sh_n;  pull_q <= pull_n;
      hi_q <= hi_n;  sel_q <= sel_n;  dseen_q <= dseen_n;  mnack_q <= mnack_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign rd_addr_o  = {sel_q, {PAD_W{1'b0}}, cnt};
  assign wr_addr_o  = rd_addr_o;
  assign wr_data_o  = sh_q;
  assign wr_req_o   = wr_fire;
  assign commit_o   = commit;

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_lvl); // R3
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> !sda_pull_o); // R9
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !wr_req_o && !commit_o); // R9
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o); // R3
  AST_COMMIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !sda_pull_o && !commit_o); // R5
endmodule

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;
  localparam int Q    = 8;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull_o, wr_req_o, commit_o, wr_protect_i, busy_i, sda_line;
  logic [15:0] rd_addr_o, wr_addr_o;
  logic [7:0]  rd_data_i, wr_data_o;

  int tests = 0, fails = 0, commit_cnt = 0, busy_cnt = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] a; logic [7:0] d; } wexp_t;
  wexp_t wq[$];
  wexp_t pend[$];
  logic [7:0] mem [0:1023];
  logic [3:0] wp_reg = 4'h0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull_o;
  assign busy_i   = (busy_cnt != 0);
  assign rd_data_i = rd_addr_o[15] ? {4'h0, wp_reg} : mem[rd_addr_o[9:0]];
  assign wr_protect_i = wr_addr_o[15] ? wp_reg[0]
                      : (wp_reg[3] && (wr_addr_o[13:12] >= (2'd3 - wp_reg[2:1])));

  i2c_mem_target i_i2c_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .busy_i(busy_i), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_protect_i(wr_protect_i), .commit_o(commit_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: page buffer, program cycle
  always @(posedge clk) begin
    if (wr_req_o) pend.push_back('{wr_addr_o, wr_data_o});
    if (commit_o) begin
      foreach (pend[i]) begin
        if (pend[i].a[15]) wp_reg <= pend[i].d[3:0];
        else mem[pend[i].a[9:0]] = pend[i].d;
      end
      pend.delete();
      busy_cnt <= BUSY;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_req_o) begin
      if (wq.size() == 0) chk("R3 unexpected write", wr_addr_o, 16'hFFFF);
      else begin
        wexp_t e;
        e = wq.pop_front();
        chk("R3 write addr", wr_addr_o, e.a);
        chk("R3 write data", {8'h00, wr_data_o}, {8'h00, e.d});
      end
    end
    if (rst_n && commit_o) commit_cnt++;
  end

  task automatic hq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hq(); m_scl = 1'b1; hq(); m_scl = 1'b0; hq();
    end
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq();
    acked = !sda_line;
    m_scl = 1'b0; hq();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq(); m_scl = 1'b1; hq();
      b = {b[6:0], sda_line};
      m_scl = 1'b0;
    end
    hq(); m_sda = give_ack ? 1'b0 : 1'b1; hq();
    m_scl = 1'b1; hq(); m_scl = 1'b0; hq(); m_sda = 1'b1;
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [7:0] d[4], input int n,
                           input bit exp_ok);
    bit k;
    int c0 = commit_cnt;
    bus_start();
    put_byte(8'hA2, k); chk("R2 select ack", 16'(k), 16'd1);
    put_byte(a[15:8], k); chk("R3 addr hi ack", 16'(k), 16'd1);
    put_byte(a[7:0], k);  chk("R3 addr lo ack", 16'(k), 16'd1);
    for (int i = 0; i < n; i++) begin
      logic [4:0] lo = 5'(a[4:0] + 5'(i));
      if (exp_ok) wq.push_back('{a[15] ? a : {a[15:5], lo}, d[i]});
      put_byte(d[i], k);
      if (exp_ok) chk("R3 data ack", 16'(k), 16'd1);
      else        chk("R10 protected data NoAck", 16'(k), 16'd0);
    end
    bus_stop();
    chk(exp_ok ? "R5 commit at stop" : "R10 no commit", 16'(commit_cnt - c0), exp_ok ? 16'd1 : 16'd0);
    chk("R3 all writes seen", 16'(wq.size()), 16'd0);
  endtask

  task automatic wait_ready();
    bit k = 1'b0;
    for (int t = 0; t < 30 && !k; t++) begin
      bus_start(); put_byte(8'hA2, k); bus_stop();
    end
    chk("R9 poll ends with ack", 16'(k), 16'd1);
  endtask

  task automatic rd_txn(input logic [15:0] a, input int n, output logic [7:0] v[4]);
    bit k;
    bus_start();
    put_byte(8'hA2, k);   chk("R6 dummy write select", 16'(k), 16'd1);
    put_byte(a[15:8], k); chk("R6 addr hi", 16'(k), 16'd1);
    put_byte(a[7:0], k);  chk("R6 addr lo", 16'(k), 16'd1);
    bus_start();
    put_byte(8'hA3, k);   chk("R6 read select", 16'(k), 16'd1);
    for (int i = 0; i < n; i++) get_byte(i != n - 1, v[i]);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit k;
    int c0;
    logic [7:0] v[4];
    logic [7:0] d[4];
    logic [7:0] b;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    hq();
    chk("R1 reset no pull", 16'(sda_pull_o), 16'd0);
    chk("R1 reset no strobes", {14'd0, wr_req_o, commit_o}, 16'd0);

    // wrong select: no ack, rest ignored
    bus_start();
    put_byte(8'hA0, k); chk("R2 mismatch NoAck", 16'(k), 16'd0);
    put_byte(8'h00, k); chk("R2 ignored until start", 16'(k), 16'd0);
    bus_stop();

    // byte write
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    mem_write(16'h0123, d, 1, 1'b1);

    // busy lockout
    bus_start();
    put_byte(8'hA2, k); chk("R9 busy select NoAck", 16'(k), 16'd0);
    bus_stop();
    wait_ready();

    // random read, then current address read
    rd_txn(16'h0123, 1, v);
    chk("R6 random read", 16'(v[0]), 16'h005A);
    bus_start();
    put_byte(8'hA3, k); chk("R7 current read select", 16'(k), 16'd1);
    get_byte(1'b0, b);
    bus_stop();
    chk("R7 current read after increment", 16'(b), 16'(mem[10'h124]));

    // page write with roll-over
    d = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
    mem_write(16'h01FE, d, 4, 1'b1);
    wait_ready();
    rd_txn(16'h01E0, 2, v);
    chk("R4 wrapped byte 0", 16'(v[0]), 16'h00C3);
    chk("R4 wrapped byte 1", 16'(v[1]), 16'h00C4);
    rd_txn(16'h01FE, 2, v);
    chk("R4 page end 0", 16'(v[0]), 16'h00C1);
    chk("R4 page end 1", 16'(v[1]), 16'h00C2);

    // stop after address only: no commit
    c0 = commit_cnt;
    bus_start();
    put_byte(8'hA2, k); put_byte(8'h02, k); put_byte(8'h00, k);
    bus_stop();
    chk("R5 no commit without data", 16'(commit_cnt - c0), 16'd0);
    chk("R5 not busy", 16'(busy_i), 16'd0);

    // sequential read across the top address
    rd_txn(16'h3FFE, 3, v);
    chk("R7 seq 0x3FFE", 16'(v[0]), 16'(mem[10'h3FE]));
    chk("R7 seq 0x3FFF", 16'(v[1]), 16'(mem[10'h3FF]));
    chk("R7 seq wrap 0x0000", 16'(v[2]), 16'(mem[10'h000]));

    // master NoAck ends the transfer
    bus_start();
    put_byte(8'hA3, k);
    get_byte(1'b0, b);
    chk("R7 counter at 0x0001", 16'(b), 16'(mem[10'h001]));
    get_byte(1'b0, b);
    chk("R8 no drive after NoAck", 16'(b), 16'h00FF);
    bus_stop();

    // protect register and protected write
    d = '{8'h08, 8'h00, 8'h00, 8'h00};
    mem_write(16'h8000, d, 1, 1'b1);
    wait_ready();
    rd_txn(16'h8000, 2, v);
    chk("R11 register read 0", 16'(v[0]), 16'h0008);
    chk("R11 register read repeats", 16'(v[1]), 16'h0008);
    d = '{8'h11, 8'h00, 8'h00, 8'h00};
    mem_write(16'h3010, d, 1, 1'b0);
    chk("R10 protected not busy", 16'(busy_i), 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule